// File: doc/BRIEF.md
# Translation Buffer with Selective Fence Invalidation

This block is a small fully associative translation cache. It maps virtual page numbers to physical page numbers for the current address space, is filled by an external page walker, and obeys address-translation fence commands. Every lookup resolves combinationally: the hit flag and the physical page appear in the same cycle as the request.

A fence request carries three fields: an "address given" flag, an "ASID given" flag, and an ASID value. Upstream logic sets each flag when the source register index for that operand is nonzero, so register zero means the operand is absent.

When the address flag is clear, the fence clears the whole buffer and also pulses an invalidate toward the walker's own cache. When the address flag is set, the page to drop is taken from the ordinary lookup address port. The compare array therefore never sees a second address multiplexer. In that case the fence clears only the entries that match the page, further narrowed by ASID when the ASID flag is set.

Top module: `tlb_fence_top`

## Requirements
- R1: A lookup hits when a valid entry holds the presented VPN and is either global or tagged with the presented ASID. In that cycle `rsp_hit` is 1 and `rsp_ppn` is the entry's PPN. Otherwise `rsp_hit` is 0 and `rsp_ppn` is 0.
- R2: A fence with `fence_addr_given` = 0 invalidates every entry, global ones included, and the effect is seen from the next cycle.
- R3: `walker_flush` is 1 exactly in the cycles where `fence_valid` = 1 and `fence_addr_given` = 0.
- R4: A fence with `fence_addr_given` = 1 and `fence_asid_given` = 0 invalidates each valid entry whose VPN equals `lk_vpn`, whatever its ASID or global bit. All other entries stay valid.
- R5: A fence with both flags set invalidates only the non-global entries whose VPN equals `lk_vpn` and whose ASID equals `fence_asid`. Global entries survive.
- R6: A lookup presented in a cycle where `fence_valid` = 1 reports a miss.
- R7: An accepted refill writes the lowest-index invalid entry, leaving every other valid entry intact.
- R8: When every entry is valid, a refill replaces the entry chosen by a round-robin pointer. The pointer is 0 after reset, advances by one on each such replacement, and wraps after the last entry.
- R9: A refill presented in the same cycle as a fence is dropped.
- R10: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page, also the page for an address fence |
| lk_asid | input | ASID_W | Current address-space ID for lookups |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page on hit, zero otherwise |
| refill_valid | input | 1 | Write a translation from the walker |
| refill_vpn | input | VPN_W | Refill virtual page |
| refill_ppn | input | PPN_W | Refill physical page |
| refill_asid | input | ASID_W | Refill address-space ID |
| refill_global | input | 1 | Refill entry is valid in every address space |
| fence_valid | input | 1 | Fence request |
| fence_addr_given | input | 1 | Page operand present (page taken from lk_vpn) |
| fence_asid_given | input | 1 | ASID operand present |
| fence_asid | input | ASID_W | ASID operand |
| walker_flush | output | 1 | Invalidate the page walker's cache |

## Verification
The buffer is loaded with eight translations that cover two ASIDs and one global page. A table of lookups then tells a plain hit apart from an ASID mismatch, a global hit across ASIDs, and an absent page. Fences are tried in each flag combination. After each fence, lookups of both the fenced page and a neighbouring page distinguish a targeted clear from an over-broad one, and a fence whose ASID matches only a global entry shows that global entries survive. Refills made after holes have been punched, and then into a full buffer, show whether the free slot or the rotating victim was chosen: the bench watches which older page disappears. A refill that coincides with a full fence shows that the refill is dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 20;
    parameter int PPN_W  = 16;
    parameter int ASID_W = 8;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [ASID_W-1:0] asid_t;

    typedef struct packed {
        logic  glob;
        asid_t asid;
        vpn_t  vpn;
        ppn_t  ppn;
    } tlb_ent_t;

    typedef struct packed {
        logic  addr_given;
        logic  asid_given;
        asid_t asid;
    } fence_req_t;

    // An entry belongs to the presented space if it is global or the IDs agree
    function automatic logic space_ok(tlb_ent_t e, asid_t a);
        return e.glob || (e.asid == a);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  tlb_ent_t   ents [N],
    input  logic [N-1:0] valid,
    input  vpn_t       cmp_vpn,
    input  asid_t      cmp_asid,
    input  fence_req_t fence,
    output logic [N-1:0] hit_vec,
    output logic [N-1:0] kill_vec
);
    // One comparator per entry serves both lookup and targeted fence
    for (genvar i = 0; i < N; i++) begin : g_ent
        logic page_eq;
        assign page_eq     = valid[i] && (ents[i].vpn == cmp_vpn);
        assign hit_vec[i]  = page_eq && space_ok(ents[i], cmp_asid);
        assign kill_vec[i] = fence.addr_given
                           ? (page_eq && (!fence.asid_given ||
                                (!ents[i].glob && ents[i].asid == fence.asid)))
                           : 1'b1;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         valid,
    input  logic                 take,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    assign full = &valid;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign idx = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst)               rr_q <= '0;
        else if (take && full) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R8: the pointer moves by exactly one step per replacement in a full buffer
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (take && full) |=> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(take && full) |=> $stable(rr_q));
endmodule

// File: rtl/tlb_fence_top.sv
module tlb_fence_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    input  logic              refill_valid,
    input  logic [VPN_W-1:0]  refill_vpn,
    input  logic [PPN_W-1:0]  refill_ppn,
    input  logic [ASID_W-1:0] refill_asid,
    input  logic              refill_global,
    input  logic              fence_valid,
    input  logic              fence_addr_given,
    input  logic              fence_asid_given,
    input  logic [ASID_W-1:0] fence_asid,
    output logic              walker_flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    tlb_ent_t           ents_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec, kill_vec;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_take;
    fence_req_t         freq;
    tlb_ent_t           new_ent;

    assign freq    = '{addr_given: fence_addr_given, asid_given: fence_asid_given, asid: fence_asid};
    assign new_ent = '{glob: refill_global, asid: refill_asid, vpn: refill_vpn, ppn: refill_ppn};

    // Fence has priority; a coincident refill is dropped
    assign fill_take = refill_valid && !fence_valid;

    tlb_match #(.N(ENTRIES)) u_match (
        .ents     (ents_q),
        .valid    (valid_q),
        .cmp_vpn  (lk_vpn),
        .cmp_asid (lk_asid),
        .fence    (freq),
        .hit_vec  (hit_vec),
        .kill_vec (kill_vec)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .valid (valid_q),
        .take  (fill_take),
        .idx   (fill_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)              valid_q <= '0;
        else if (fence_valid) valid_q <= valid_q & ~kill_vec;
        else if (fill_take)   valid_q[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_take) ents_q[fill_idx] <= new_ent;
    end

    always_comb begin
        rsp_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) rsp_ppn = rsp_ppn | ents_q[i].ppn;
        end
        rsp_hit = lk_valid && !fence_valid && (|hit_vec);
        if (!rsp_hit) rsp_ppn = '0;
    end

    assign walker_flush = fence_valid && !fence_addr_given;

    // R2: a full fence leaves nothing valid
    a_r2_full_clear: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && !fence_addr_given) |=> (valid_q == '0));
    // R4: a targeted fence never adds entries
    a_r4_no_grow: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && fence_addr_given) |=> ($countones(valid_q) <= $countones($past(valid_q))));
    // R7: a refill into a non-full buffer adds exactly one entry
    a_r7_adds_one: assert property (@(posedge clk) disable iff (rst)
        (fill_take && !(&valid_q)) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
    // R9: a refill during a fence never raises the valid count
    a_r9_fence_wins: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && refill_valid) |=> ($countones(valid_q) <= $countones($past(valid_q))));
    // R1: the bench never installs duplicate pages, so at most one entry matches
    a_r1_single_hit: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(hit_vec));
    // R5: global entries survive an ASID-qualified page fence
    for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
        a_r5_global_kept: assert property (@(posedge clk) disable iff (rst)
            (fence_valid && fence_addr_given && fence_asid_given &&
             valid_q[i] && ents_q[i].glob) |=> valid_q[i]);
    end
endmodule

// File: tb/sim_tlb_fence_top.sv
module sim_tlb_fence_top;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              lk_valid;
    logic [VPN_W-1:0]  lk_vpn;
    logic [ASID_W-1:0] lk_asid;
    logic              rsp_hit;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              refill_valid;
    logic [VPN_W-1:0]  refill_vpn;
    logic [PPN_W-1:0]  refill_ppn;
    logic [ASID_W-1:0] refill_asid;
    logic              refill_global;
    logic              fence_valid;
    logic              fence_addr_given;
    logic              fence_asid_given;
    logic [ASID_W-1:0] fence_asid;
    logic              walker_flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tlb_fence_top u0 (.*);

    // Lookup table: vpn, asid, expected hit, expected ppn
    localparam int NV = 6;
    localparam int V_VPN  [NV] = '{32'h100, 32'h105, 32'h107, 32'h105, 32'h200, 32'h103};
    localparam int V_ASID [NV] = '{1, 1, 1, 2, 1, 1};
    localparam int V_HIT  [NV] = '{1, 0, 1, 1, 0, 1};
    localparam int V_PPN  [NV] = '{32'hA00, 0, 32'hA07, 32'hA05, 0, 32'hA03};

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_vpn = '0; lk_asid = '0;
        refill_valid = 0; refill_vpn = '0; refill_ppn = '0; refill_asid = '0; refill_global = 0;
        fence_valid = 0; fence_addr_given = 0; fence_asid_given = 0; fence_asid = '0;
    endtask

    task automatic look(string req, int vpn, int asid, int eh, int ep);
        @(negedge clk);
        idle_inputs();
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
        #2;
        chk(req, int'(rsp_hit), eh);
        chk(req, int'(rsp_ppn), ep);
    endtask

    task automatic fill(int vpn, int ppn, int asid, bit g);
        @(negedge clk);
        idle_inputs();
        refill_valid = 1; refill_vpn = VPN_W'(vpn); refill_ppn = PPN_W'(ppn);
        refill_asid = ASID_W'(asid); refill_global = g;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    // Fence with a concurrent lookup; R6 and R3 are checked in the fence cycle
    task automatic fence(string req, bit ag, bit sg, int fa, int vpn, int lasid, bit also_fill);
        @(negedge clk);
        idle_inputs();
        fence_valid = 1; fence_addr_given = ag; fence_asid_given = sg; fence_asid = ASID_W'(fa);
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(lasid);
        if (also_fill) begin
            refill_valid = 1; refill_vpn = 20'h400; refill_ppn = 16'hB40; refill_asid = 8'd1;
        end
        #2;
        chk({req, " R6 miss during fence"}, int'(rsp_hit), 0);
        chk({req, " R3 walker flush"}, int'(walker_flush), int'(!ag));
        @(posedge clk); #1;
        idle_inputs();
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R10: nothing valid after reset
        look("R10 reset miss", 32'h100, 1, 0, 0);
        @(negedge clk); #2;
        chk("R10/R3 walker flush idle", int'(walker_flush), 0);

        // Load eight entries: idx i -> vpn 0x100+i, ppn 0xA00+i
        for (int i = 0; i < 8; i++)
            fill(32'h100 + i, 32'hA00 + i, (i < 4) ? 1 : 2, i == 7);

        // R1: table of lookups
        for (int k = 0; k < NV; k++)
            look($sformatf("R1 table %0d", k), V_VPN[k], V_ASID[k], V_HIT[k], V_PPN[k]);

        // R6/R5: fence whose ASID matches nothing; lookup in that cycle misses
        fence("R5 asid3", 1, 1, 3, 32'h105, 2, 0);
        look("R5 asid mismatch kept", 32'h105, 2, 1, 32'hA05);

        // R4: page-only fence
        fence("R4 page", 1, 0, 0, 32'h101, 1, 0);
        look("R4 fenced page gone", 32'h101, 1, 0, 0);
        look("R4 neighbour kept", 32'h102, 1, 1, 32'hA02);

        // R5: ASID matches a global entry, which survives
        fence("R5 global", 1, 1, 2, 32'h107, 2, 0);
        look("R5 global survives", 32'h107, 1, 1, 32'hA07);

        // R5: non-global ASID match removed
        fence("R5 nonglobal", 1, 1, 1, 32'h102, 1, 0);
        look("R5 nonglobal gone", 32'h102, 1, 0, 0);

        // R7: holes at idx 1 and 2 are filled first
        fill(32'h300, 32'hC00, 1, 0);
        fill(32'h301, 32'hC01, 1, 0);
        look("R7 old idx0 kept", 32'h100, 1, 1, 32'hA00);
        look("R7 old idx3 kept", 32'h103, 1, 1, 32'hA03);
        look("R7 old idx6 kept", 32'h106, 2, 1, 32'hA06);
        look("R7 new 0x300", 32'h300, 1, 1, 32'hC00);
        look("R7 new 0x301", 32'h301, 1, 1, 32'hC01);

        // R8: full buffer, pointer 0 then 1 then 2
        fill(32'h302, 32'hC02, 1, 0);
        look("R8 idx0 replaced", 32'h100, 1, 0, 0);
        look("R8 new in idx0", 32'h302, 1, 1, 32'hC02);
        fill(32'h303, 32'hC03, 1, 0);
        look("R8 idx1 replaced", 32'h300, 1, 0, 0);
        look("R8 idx2 kept", 32'h301, 1, 1, 32'hC01);
        fill(32'h304, 32'hC04, 1, 0);
        look("R8 idx2 replaced", 32'h301, 1, 0, 0);
        look("R8 idx3 kept", 32'h103, 1, 1, 32'hA03);

        // R2/R9: full fence with coincident refill
        fence("R2 full", 0, 0, 0, 32'h107, 1, 1);
        look("R2 global cleared", 32'h107, 1, 0, 0);
        look("R2 entry cleared", 32'h303, 1, 0, 0);
        look("R9 refill dropped", 32'h400, 1, 0, 0);

        // R7: usable again after a flush
        fill(32'h500, 32'hD00, 1, 0);
        look("R7 refill after flush", 32'h500, 1, 1, 32'hD00);
        look("R1 wrong asid miss", 32'h500, 2, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule